// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Unit

This unit sits between the command decoder of a serial EEPROM and its array and status storage, and decides whether each write request may proceed. It holds the write-enable latch and the non-volatile protection bits: a two-bit block-protect level and a hardware-pin enable bit. For every request it compares the target segment, the enable latch and the state of the external write-protect pin against those bits. It then issues a one-cycle grant and, for an allowed status write, loads the new protection bits.

The array is split into four equal segments, selected by the two most significant address bits. The block-protect level can leave the array open, lock the highest segment, lock the upper two segments, or lock the whole array. The external pin guards the status register only after the pin-enable bit has been set. While that bit is clear, the pin is ignored, so a board can tie the pin low and still reprogram protection.

Top module: `eeprom_wprot`

## Requirements
- R1: After reset, `grant` is 0, `nvBits` is 000 and `statusByte` reads 0 except bit 0, which follows `busyIn`.
- R2: Request kinds are encoded 00 set latch, 01 clear latch, 10 array write, 11 status write. Set latch makes `statusByte[1]` 1 and clear latch makes it 0, with no grant.
- R3: With the latch clear, no array or status write is granted and the protection bits do not change.
- R4: Block-protect level encoding is 00 open, 01 highest segment (address top bits 11), 10 upper half (top address bit 1) and 11 all. An array write to a locked segment is not granted, and a write elsewhere with the latch set is.
- R5: A refused array write still clears the latch.
- R6: With the pin-enable bit 0, a status write with the latch set is granted whatever the level of `wpN`.
- R7: With the pin-enable bit 1 and `wpN` low, a status write is refused, the protection bits keep their value and the latch is cleared. With `wpN` high, the write is granted.
- R8: `statusByte` layout is bit 7 pin-enable, bits 3:2 block-protect level, bit 1 latch, bit 0 busy, and the other bits are 0. A granted status write captures only `reqData[7]` and `reqData[3:2]`.
- R9: `grant` is high for exactly the cycle after the clock edge that accepted the request. Any accepted array or status write leaves the latch clear.
- R10: While `busyIn` is 1, requests are ignored, with no grant and no latch or protection-bit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | Request kind (see R2) |
| reqAddr | input | ADDR_W | Target array address |
| reqData | input | 8 | New status byte for a status write |
| wpN | input | 1 | External write-protect pin, low asserts |
| busyIn | input | 1 | Array programming in progress |
| grant | output | 1 | One-cycle permission pulse |
| statusByte | output | 8 | Readable status byte |
| nvBits | output | 3 | Protection bits {pin-enable, level[1:0]} |

## Verification
The assertions assume that `reqKind`, `reqAddr`, `reqData` and `wpN` are stable and defined whenever `reqValid` is sampled high. They also assume that `busyIn` changes only between requests. The bench drives every input on the falling clock edge and holds each request for exactly one rising edge, so each request is sampled once. It keeps `busyIn` constant for the whole of a request.

// File: rtl/eeprom_wprot_pkg.sv
package eeprom_wprot_pkg;

  typedef enum logic [1:0] {
    KIND_SETWEL = 2'd0,
    KIND_CLRWEL = 2'd1,
    KIND_ARRAY  = 2'd2,
    KIND_STATUS = 2'd3
  } reqKind_e;

  // Strobes from the decision logic to the register datapath
  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       loadNv;
    logic       grantNext;
    logic [2:0] nvNext;   // {pin enable, level[1:0]}
  } ctrlStrobe_t;

  localparam int SEG_BITS = 2;

endpackage

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
  import eeprom_wprot_pkg::*;
(
  input  logic                reqValid,
  input  logic [1:0]          reqKind,
  input  logic [SEG_BITS-1:0] segSel,
  input  logic [2:0]          dataNv,
  input  logic                wpN,
  input  logic                busyIn,
  input  logic                welQ,
  input  logic                wpenQ,
  input  logic [1:0]          bpQ,
  output ctrlStrobe_t         strobe
);
  localparam int NUM_SEG = 1 << SEG_BITS;

  logic [NUM_SEG-1:0] segLocked;
  logic addrLocked;
  logic statusBlocked;
  logic accept;

  // One lock flag per segment, derived from the selected level
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam bit IN_TOP_QUARTER = (s >= NUM_SEG - NUM_SEG/4);
    localparam bit IN_TOP_HALF    = (s >= NUM_SEG/2);
    assign segLocked[s] = (bpQ == 2'b11)
                       || ((bpQ == 2'b10) && IN_TOP_HALF)
                       || ((bpQ == 2'b01) && IN_TOP_QUARTER);
  end

  assign addrLocked    = segLocked[segSel];
  assign statusBlocked = wpenQ && !wpN;
  assign accept        = reqValid && !busyIn;

  always_comb begin
    strobe        = '0;
    strobe.nvNext = dataNv;
    case (reqKind_e'(reqKind))
      KIND_SETWEL: strobe.setWel = accept;
      KIND_CLRWEL: strobe.clrWel = accept;
      KIND_ARRAY: begin
        strobe.clrWel    = accept;
        strobe.grantNext = accept && welQ && !addrLocked;
      end
      default: begin
        strobe.clrWel    = accept;
        strobe.grantNext = accept && welQ && !statusBlocked;
        strobe.loadNv    = accept && welQ && !statusBlocked;
      end
    endcase
  end

endmodule

// File: rtl/eeprom_wprot_dp.sv
module eeprom_wprot_dp
  import eeprom_wprot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        busyIn,
  output logic        welQ,
  output logic        wpenQ,
  output logic [1:0]  bpQ,
  output logic        grant,
  output logic [7:0]  statusByte
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      wpenQ <= 1'b0;
      bpQ   <= 2'b00;
      grant <= 1'b0;
    end else begin
      grant <= strobe.grantNext;
      if (strobe.setWel)      welQ <= 1'b1;
      else if (strobe.clrWel) welQ <= 1'b0;
      if (strobe.loadNv) begin
        wpenQ <= strobe.nvNext[2];
        bpQ   <= strobe.nvNext[1:0];
      end
    end
  end

  assign statusByte = {wpenQ, 3'b000, bpQ, welQ, busyIn};

  // R9: a grant never lasts two cycles
  assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);

  // R3: a grant needs the latch to have been set
  assert_grant_needs_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> $past(welQ));

  // R8: protection bits only move together with a grant
  assert_nv_moves_with_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({wpenQ, bpQ}) |-> grant);

endmodule

// File: rtl/eeprom_wprot.sv
module eeprom_wprot
  import eeprom_wprot_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              wpN,
  input  logic              busyIn,
  output logic              grant,
  output logic [7:0]        statusByte,
  output logic [2:0]        nvBits
);
  ctrlStrobe_t strobe;
  logic welQ, wpenQ;
  logic [1:0] bpQ;
  logic unusedInputs;

  assign unusedInputs = ^{reqAddr[ADDR_W-SEG_BITS-1:0], reqData[6:4], reqData[1:0]};

  eeprom_wprot_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .segSel   (reqAddr[ADDR_W-1 -: SEG_BITS]),
    .dataNv   ({reqData[7], reqData[3:2]}),
    .wpN      (wpN),
    .busyIn   (busyIn),
    .welQ     (welQ),
    .wpenQ    (wpenQ),
    .bpQ      (bpQ),
    .strobe   (strobe)
  );

  eeprom_wprot_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busyIn     (busyIn),
    .welQ       (welQ),
    .wpenQ      (wpenQ),
    .bpQ        (bpQ),
    .grant      (grant),
    .statusByte (statusByte)
  );

  assign nvBits = {wpenQ, bpQ};

  // R7: pin-guarded status write is never granted
  assert_pin_blocks_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busyIn && reqKind == 2'd3 && wpenQ && !wpN) |=> (!grant && $stable(nvBits)));

  // R4: full-array lock refuses every array write
  assert_full_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busyIn && reqKind == 2'd2 && bpQ == 2'b11) |=> !grant);

  // R9 / R5: an accepted write leaves the latch clear
  assert_write_clears_latch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busyIn && reqKind[1]) |=> !statusByte[1]);

  // R10: requests during busy change nothing
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && busyIn) |=> (!grant && $stable(statusByte[7:1])));

endmodule

// File: tb/tb_eeprom_wprot.sv
module tb_eeprom_wprot;
  localparam int ADDR_W = 14;
  localparam int NVEC = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqData = 8'h00;
  logic wpN = 1'b1;
  logic busyIn = 1'b0;
  logic grant;
  logic [7:0] statusByte;
  logic [2:0] nvBits;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eeprom_wprot #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .wpN(wpN), .busyIn(busyIn),
    .grant(grant), .statusByte(statusByte), .nvBits(nvBits)
  );

  // {kind[2], wpN, addr[14], data[8], expGrant, expStatus[8]}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd3,1'b1,14'h0000,8'hFF,1'b0,8'h00}, // R3 status write without latch
    {2'd2,1'b1,14'h0000,8'h00,1'b0,8'h00}, // R3 array write without latch
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h02}, // R2 set
    {2'd1,1'b1,14'h0000,8'h00,1'b0,8'h00}, // R2 clear
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h02},
    {2'd2,1'b1,14'h3FFF,8'h00,1'b1,8'h00}, // R4 open level
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h02},
    {2'd3,1'b1,14'h0000,8'h04,1'b1,8'h04}, // R8 level 01
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h06},
    {2'd2,1'b1,14'h3FFF,8'h00,1'b0,8'h04}, // R5 locked top segment
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h06},
    {2'd2,1'b1,14'h2FFF,8'h00,1'b1,8'h04}, // R4 segment 2 open
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h06},
    {2'd3,1'b1,14'h0000,8'h7B,1'b1,8'h08}, // R8 masked capture
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h0A},
    {2'd2,1'b1,14'h2000,8'h00,1'b0,8'h08}, // R4 upper half locked
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h0A},
    {2'd2,1'b1,14'h1FFF,8'h00,1'b1,8'h08}, // R4 lower half open
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h0A},
    {2'd3,1'b0,14'h0000,8'h0C,1'b1,8'h0C}, // R6 pin low, enable 0
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h0E},
    {2'd2,1'b1,14'h0000,8'h00,1'b0,8'h0C}, // R4 whole array
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h0E},
    {2'd3,1'b1,14'h0000,8'h8C,1'b1,8'h8C}, // R7 set pin enable
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h8E},
    {2'd3,1'b0,14'h0000,8'h00,1'b0,8'h8C}, // R7 refused, latch cleared
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h8E},
    {2'd3,1'b1,14'h0000,8'h00,1'b1,8'h00}, // R7 pin high granted
    {2'd0,1'b1,14'h0000,8'h00,1'b0,8'h02},
    {2'd2,1'b1,14'h0000,8'h00,1'b1,8'h00}  // R4 back to open
  };

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; wpN = w; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkVal("R1 grant", {7'd0, grant}, 8'h00);
    checkVal("R1 status", statusByte, 8'h00);
    checkVal("R1 nv", {5'd0, nvBits}, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][33:32], VEC[i][31], VEC[i][30:17], VEC[i][16:9]);
      checkVal($sformatf("vec%0d grant", i), {7'd0, grant}, {7'd0, VEC[i][8]});
      checkVal($sformatf("vec%0d status", i), statusByte, VEC[i][7:0]);
    end

    // R9: grant drops the cycle after
    @(negedge clk);
    checkVal("R9 grant one cycle", {7'd0, grant}, 8'h00);

    // R10: busy ignores requests, bit 0 follows busy
    busyIn = 1'b1;
    issue(2'd0, 1'b1, '0, 8'h00);
    checkVal("R10 set ignored", statusByte, 8'h01);
    issue(2'd3, 1'b1, '0, 8'h8C);
    checkVal("R10 status write ignored", {5'd0, nvBits}, 8'h00);
    checkVal("R10 no grant", {7'd0, grant}, 8'h00);
    busyIn = 1'b0;

    // R9: refused writes clear the latch too
    issue(2'd0, 1'b1, '0, 8'h00);
    issue(2'd3, 1'b1, '0, 8'h0C);
    checkVal("R9 granted status", statusByte, 8'h0C);
    issue(2'd0, 1'b1, '0, 8'h00);
    issue(2'd2, 1'b1, 14'h1234, 8'h00);
    checkVal("R5 refused array clears latch", statusByte, 8'h0C);

    // R1: reset in mid-run restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    checkVal("R1 reset again status", statusByte, 8'h00);
    checkVal("R1 reset again nv", {5'd0, nvBits}, 8'h00);
    rstN = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule